// File: doc/BRIEF.md
# GPIO Pin Control Register Bank

This block is the register bank that sits between a simple memory-mapped bus and the pad ring for a group of 32 general-purpose pins. Software writes per-pin settings for drive level, drive enable, pull resistor, alternate function and behaviour during sleep; the bank turns those settings into the per-pin signals that a pad multiplexer consumes. Pin levels coming back from the pads are retimed through a two-stage synchronizer and can be read at a dedicated address.

Drive level and drive enable are changed through separate set and clear addresses, so software can change a subset of pins with a single write and no read-modify-write. The pull direction has no register of its own: it is taken from each pin's drive-level bit. A sleep request input switches the pad outputs combinationally to their sleep view, in which pins not marked to keep their state become GPIO inputs with their pull left as configured.

Top module: `gpio_bank`

## Requirements
- R1: After reset every register reads 0: the drive-level, direction, pull-disable, both function-select and sleep-keep registers, so every pin is a GPIO input (padOe = 0, padFunc = 0) with its pull enabled toward 0.
- R2: A write to address 1 sets the drive-level bits written as 1 and a write to address 2 clears them; bits written as 0 keep their value, and padOut shows the drive-level register.
- R3: A write to address 3 makes the pins written as 1 outputs and a write to address 4 makes them inputs; other pins keep their direction, and padOe shows the direction register outside sleep.
- R4: The pull-disable register at address 5 holds one bit per pin; a 1 turns that pin's pull off and a 0 turns it on, seen on padPullEn as the inverted register.
- R5: padPullUp equals each pin's drive-level bit: 1 selects pull-up, 0 pull-down, so setting a pull level also changes the level driven by an output pin.
- R6: Function-select bit 0 lives at address 6 and bit 1 at address 7; pin i's code appears on padFunc[2i+1:2i] with 00 = GPIO, 01 = function A, 10 = function B, 11 = function C.
- R7: The sleep-keep register at address 8 holds one bit per pin; while sleepReq is 1, a pin whose bit is 0 has padOe = 0 and padFunc = 00 while padPullEn, padPullUp and padOut are unchanged, and a pin whose bit is 1 keeps its normal outputs.
- R8: A read of address 0 returns the pin levels after a two-flop synchronizer: a change on pinIn driven between edges is visible on busRdata after the second following rising edge and not after the first.
- R9: Reads of addresses 1 and 2 return the drive-level register and reads of 3 and 4 return the direction register; a write updates at most one register, and a write to address 0 or to an unmapped address (9 to 15, which read 0) changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | ADDR_W (4) | Word address of the register accessed |
| busWdata | input | NUM_PINS (32) | Write data |
| busWe | input | 1 | Write enable, one write per cycle in which it is high |
| busRdata | output | NUM_PINS (32) | Combinational read data for busAddr |
| pinIn | input | NUM_PINS (32) | Asynchronous pin levels from the pads |
| sleepReq | input | 1 | Applies the sleep view to the pad outputs while high |
| padOut | output | NUM_PINS (32) | Per-pin drive level |
| padOe | output | NUM_PINS (32) | Per-pin output enable |
| padPullEn | output | NUM_PINS (32) | Per-pin pull resistor enable |
| padPullUp | output | NUM_PINS (32) | Per-pin pull direction, 1 = up |
| padFunc | output | 2*NUM_PINS (64) | Per-pin 2-bit function select toward the pad mux |

## Verification
On every cycle the assertions check that a set or clear write changes exactly the written bits of the drive level and nothing else, that direction holds whenever no direction write occurs, that the decoder never raises two write strobes at once, and that no sleeping pin without its keep bit is left driving. The function-select encoding per pin, the coupling of pull direction to drive level, the read-back aliasing of the set and clear addresses, ignored writes to the pin-level address and the exact two-edge synchronizer latency are shown only by the bench's scenarios, which compare port values against expectations derived from the requirements.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  // Word addresses of the bank
  typedef enum logic [3:0] {
    ADDR_PINLVL    = 4'd0,
    ADDR_OUTSET    = 4'd1,
    ADDR_OUTCLR    = 4'd2,
    ADDR_DIRSET    = 4'd3,
    ADDR_DIRCLR    = 4'd4,
    ADDR_PULLOFF   = 4'd5,
    ADDR_FSEL0     = 4'd6,
    ADDR_FSEL1     = 4'd7,
    ADDR_SLEEPKEEP = 4'd8
  } regAddr_e;

  // Read source chosen by the control
  typedef enum logic [2:0] {
    RD_PINLVL,
    RD_OUTDATA,
    RD_DIR,
    RD_PULLOFF,
    RD_FSEL0,
    RD_FSEL1,
    RD_SLEEPKEEP,
    RD_ZERO
  } rdSel_e;

  // Write strobes, at most one high per cycle
  typedef struct packed {
    logic outSet;
    logic outClr;
    logic dirSet;
    logic dirClr;
    logic pullOff;
    logic fsel0;
    logic fsel1;
    logic sleepKeep;
  } wrStrobes_t;

  typedef struct packed {
    wrStrobes_t wr;
    rdSel_e     rd;
  } ctrlBus_t;

endpackage

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  output ctrlBus_t          ctl
);

  logic [3:0] addrLow;
  logic       addrInRange;

  generate
    if (ADDR_W > 4) begin : gWide
      assign addrLow     = busAddr[3:0];
      assign addrInRange = (busAddr[ADDR_W-1:4] == '0);
    end else begin : gNarrow
      assign addrLow     = 4'(busAddr);
      assign addrInRange = 1'b1;
    end
  endgenerate

  always_comb begin
    ctl = '0;
    ctl.rd = RD_ZERO;
    if (addrInRange) begin
      unique case (addrLow)
        ADDR_PINLVL:    ctl.rd = RD_PINLVL;
        ADDR_OUTSET:    begin ctl.rd = RD_OUTDATA;   ctl.wr.outSet    = busWe; end
        ADDR_OUTCLR:    begin ctl.rd = RD_OUTDATA;   ctl.wr.outClr    = busWe; end
        ADDR_DIRSET:    begin ctl.rd = RD_DIR;       ctl.wr.dirSet    = busWe; end
        ADDR_DIRCLR:    begin ctl.rd = RD_DIR;       ctl.wr.dirClr    = busWe; end
        ADDR_PULLOFF:   begin ctl.rd = RD_PULLOFF;   ctl.wr.pullOff   = busWe; end
        ADDR_FSEL0:     begin ctl.rd = RD_FSEL0;     ctl.wr.fsel0     = busWe; end
        ADDR_FSEL1:     begin ctl.rd = RD_FSEL1;     ctl.wr.fsel1     = busWe; end
        ADDR_SLEEPKEEP: begin ctl.rd = RD_SLEEPKEEP; ctl.wr.sleepKeep = busWe; end
        default:        ctl.rd = RD_ZERO;
      endcase
    end
  end

  // R9: a single write never reaches two registers
  assert_one_write_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(ctl.wr));

  // R9: without a write enable no strobe is raised
  assert_no_write_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    !busWe |-> (ctl.wr == '0));

endmodule

// File: rtl/gpio_bank_dp.sv
module gpio_bank_dp
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS    = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrlBus_t              ctl,
  input  logic [NUM_PINS-1:0]   busWdata,
  output logic [NUM_PINS-1:0]   busRdata,
  input  logic [NUM_PINS-1:0]   pinIn,
  input  logic                  sleepReq,
  output logic [NUM_PINS-1:0]   padOut,
  output logic [NUM_PINS-1:0]   padOe,
  output logic [NUM_PINS-1:0]   padPullEn,
  output logic [NUM_PINS-1:0]   padPullUp,
  output logic [2*NUM_PINS-1:0] padFunc
);

  localparam int FUNC_W = 2;

  logic [NUM_PINS-1:0] dataReg, dirReg, pullOffReg, fsel0Reg, fsel1Reg, keepReg;
  logic [NUM_PINS-1:0] syncStage [SYNC_STAGES];
  logic [NUM_PINS-1:0] pinLevel;
  logic [NUM_PINS-1:0] activeMask;

  // Configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataReg    <= '0;
      dirReg     <= '0;
      pullOffReg <= '0;
      fsel0Reg   <= '0;
      fsel1Reg   <= '0;
      keepReg    <= '0;
    end else begin
      if (ctl.wr.outSet)    dataReg    <= dataReg | busWdata;
      if (ctl.wr.outClr)    dataReg    <= dataReg & ~busWdata;
      if (ctl.wr.dirSet)    dirReg     <= dirReg | busWdata;
      if (ctl.wr.dirClr)    dirReg     <= dirReg & ~busWdata;
      if (ctl.wr.pullOff)   pullOffReg <= busWdata;
      if (ctl.wr.fsel0)     fsel0Reg   <= busWdata;
      if (ctl.wr.fsel1)     fsel1Reg   <= busWdata;
      if (ctl.wr.sleepKeep) keepReg    <= busWdata;
    end
  end

  // Input synchronizer chain
  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : gSync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)       syncStage[s] <= '0;
        else if (s == 0) syncStage[s] <= pinIn;
        else             syncStage[s] <= syncStage[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate
  assign pinLevel = syncStage[SYNC_STAGES-1];

  // Read mux
  always_comb begin
    unique case (ctl.rd)
      RD_PINLVL:    busRdata = pinLevel;
      RD_OUTDATA:   busRdata = dataReg;
      RD_DIR:       busRdata = dirReg;
      RD_PULLOFF:   busRdata = pullOffReg;
      RD_FSEL0:     busRdata = fsel0Reg;
      RD_FSEL1:     busRdata = fsel1Reg;
      RD_SLEEPKEEP: busRdata = keepReg;
      default:      busRdata = '0;
    endcase
  end

  // Pad view, with sleep gating
  assign activeMask = sleepReq ? keepReg : '1;
  assign padOut     = dataReg;
  assign padOe      = dirReg & activeMask;
  assign padPullEn  = ~pullOffReg;
  assign padPullUp  = dataReg;

  generate
    for (genvar p = 0; p < NUM_PINS; p++) begin : gFunc
      assign padFunc[FUNC_W*p +: FUNC_W] =
        activeMask[p] ? {fsel1Reg[p], fsel0Reg[p]} : 2'b00;
    end
  endgenerate

  // R2: a set write adds exactly the written ones to the drive level
  assert_out_set_R2: assert property (@(posedge clk) disable iff (!rstN)
    ctl.wr.outSet |=> padOut == ($past(padOut) | $past(busWdata)));

  // R2: a clear write removes exactly the written ones
  assert_out_clr_R2: assert property (@(posedge clk) disable iff (!rstN)
    ctl.wr.outClr |=> padOut == ($past(padOut) & ~$past(busWdata)));

  // R2: without a data write the drive level holds
  assert_out_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(ctl.wr.outSet || ctl.wr.outClr) |=> $stable(padOut));

  // R3: direction only moves on a direction write
  assert_dir_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(ctl.wr.dirSet || ctl.wr.dirClr) |=> $stable(dirReg));

  // R7: a sleeping pin without its keep bit never drives
  assert_sleep_input_R7: assert property (@(posedge clk) disable iff (!rstN)
    sleepReq |-> ((padOe & ~keepReg) == '0));

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int ADDR_W   = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [ADDR_W-1:0]     busAddr,
  input  logic [NUM_PINS-1:0]   busWdata,
  input  logic                  busWe,
  output logic [NUM_PINS-1:0]   busRdata,
  input  logic [NUM_PINS-1:0]   pinIn,
  input  logic                  sleepReq,
  output logic [NUM_PINS-1:0]   padOut,
  output logic [NUM_PINS-1:0]   padOe,
  output logic [NUM_PINS-1:0]   padPullEn,
  output logic [NUM_PINS-1:0]   padPullUp,
  output logic [2*NUM_PINS-1:0] padFunc
);

  ctrlBus_t ctl;

  gpio_bank_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .busAddr (busAddr),
    .busWe   (busWe),
    .ctl     (ctl)
  );

  gpio_bank_dp #(.NUM_PINS(NUM_PINS), .SYNC_STAGES(2)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .busWdata  (busWdata),
    .busRdata  (busRdata),
    .pinIn     (pinIn),
    .sleepReq  (sleepReq),
    .padOut    (padOut),
    .padOe     (padOe),
    .padPullEn (padPullEn),
    .padPullUp (padPullUp),
    .padFunc   (padFunc)
  );

endmodule

// File: tb/tb_gpio_bank.sv
`timescale 1ns/1ps
module tb_gpio_bank;

  localparam int NP = 32;
  localparam int AW = 4;

  localparam int K_RD   = 0;
  localparam int K_OUT  = 1;
  localparam int K_OE   = 2;
  localparam int K_PEN  = 3;
  localparam int K_PUP  = 4;
  localparam int K_FUNC = 5;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [AW-1:0]   busAddr = '0;
  logic [NP-1:0]   busWdata = '0;
  logic            busWe = 1'b0;
  logic [NP-1:0]   busRdata;
  logic [NP-1:0]   pinIn = '0;
  logic            sleepReq = 1'b0;
  logic [NP-1:0]   padOut, padOe, padPullEn, padPullUp;
  logic [2*NP-1:0] padFunc;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    int          kind;
    logic [63:0] exp;
    string       tag;
  } item_t;
  item_t q[$];

  gpio_bank #(.NUM_PINS(NP), .ADDR_W(AW)) dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWdata(busWdata),
    .busWe(busWe), .busRdata(busRdata), .pinIn(pinIn), .sleepReq(sleepReq),
    .padOut(padOut), .padOe(padOe), .padPullEn(padPullEn),
    .padPullUp(padPullUp), .padFunc(padFunc)
  );

  always #4 clk = ~clk;

  // Monitor: pops expectations one ns after each rising edge
  item_t       curItem;
  logic [63:0] actVal;
  always @(posedge clk) begin
    #1;
    while (q.size() > 0) begin
      curItem = q.pop_front();
      case (curItem.kind)
        K_RD:    actVal = {32'b0, busRdata};
        K_OUT:   actVal = {32'b0, padOut};
        K_OE:    actVal = {32'b0, padOe};
        K_PEN:   actVal = {32'b0, padPullEn};
        K_PUP:   actVal = {32'b0, padPullUp};
        default: actVal = padFunc;
      endcase
      checks++;
      if (actVal !== curItem.exp) begin
        fails++;
        $display("FAIL %s kind %0d actual %h expected %h",
                 curItem.tag, curItem.kind, actVal, curItem.exp);
      end
    end
  end

  task automatic step();
    @(negedge clk);
  endtask

  task automatic expectVal(input int kind, input logic [63:0] exp, input string tag);
    item_t it;
    it.kind = kind;
    it.exp  = exp;
    it.tag  = tag;
    q.push_back(it);
  endtask

  task automatic busWrite(input logic [AW-1:0] a, input logic [NP-1:0] d);
    @(negedge clk);
    busAddr  = a;
    busWdata = d;
    busWe    = 1'b1;
    @(negedge clk);
    busWe    = 1'b0;
  endtask

  task automatic busRead(input logic [AW-1:0] a, input logic [NP-1:0] exp, input string tag);
    step();
    busAddr = a;
    expectVal(K_RD, {32'b0, exp}, tag);
  endtask

  task automatic finishRun();
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired, actual hang expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    step();
    expectVal(K_OE,   64'h0, "R1");
    expectVal(K_FUNC, 64'h0, "R1");
    expectVal(K_PEN,  64'hFFFF_FFFF, "R1");
    expectVal(K_OUT,  64'h0, "R1");
    busRead(4'd1, 32'h0, "R1");
    busRead(4'd3, 32'h0, "R1");
    busRead(4'd5, 32'h0, "R1");
    busRead(4'd6, 32'h0, "R1");
    busRead(4'd7, 32'h0, "R1");
    busRead(4'd8, 32'h0, "R1");

    // R2: set and clear of drive level
    busWrite(4'd1, 32'h0000_00F0);
    busWrite(4'd1, 32'h0000_000F);
    step();
    expectVal(K_OUT, 64'hFF, "R2");
    busWrite(4'd2, 32'h0000_0011);
    step();
    expectVal(K_OUT, 64'hEE, "R2");
    busRead(4'd1, 32'h0000_00EE, "R2");
    busRead(4'd2, 32'h0000_00EE, "R9");

    // R3: direction set and clear
    busWrite(4'd3, 32'hFFFF_0000);
    busWrite(4'd4, 32'h0F00_0000);
    step();
    expectVal(K_OE, 64'hF0FF_0000, "R3");
    busRead(4'd4, 32'hF0FF_0000, "R9");

    // R4: pull disable
    busWrite(4'd5, 32'h0000_FFFF);
    step();
    expectVal(K_PEN, 64'hFFFF_0000, "R4");
    busRead(4'd5, 32'h0000_FFFF, "R4");

    // R5: pull direction follows drive level
    step();
    expectVal(K_PUP, 64'hEE, "R5");
    busWrite(4'd1, 32'h0001_0100);
    step();
    expectVal(K_PUP, 64'h0001_01EE, "R5");
    expectVal(K_OUT, 64'h0001_01EE, "R5");

    // R6: function select encoding, pins 0..2 = A, B, C
    busWrite(4'd6, 32'h0000_0005);
    busWrite(4'd7, 32'h0000_0006);
    step();
    expectVal(K_FUNC, 64'h39, "R6");
    busRead(4'd7, 32'h0000_0006, "R6");

    // R7: sleep view, only pin 16 kept
    busWrite(4'd8, 32'h0001_0000);
    step();
    sleepReq = 1'b1;
    expectVal(K_OE,   64'h0001_0000, "R7");
    expectVal(K_FUNC, 64'h0, "R7");
    expectVal(K_PEN,  64'hFFFF_0000, "R7");
    expectVal(K_PUP,  64'h0001_01EE, "R7");
    // keep pins 0 and 16 now: pin 0 function A survives, pin 0 is an input
    busWrite(4'd8, 32'h0001_0001);
    step();
    expectVal(K_FUNC, 64'h1, "R7");
    expectVal(K_OE,   64'h0001_0000, "R7");
    step();
    sleepReq = 1'b0;
    expectVal(K_OE,   64'hF0FF_0000, "R7");
    expectVal(K_FUNC, 64'h39, "R7");

    // R8: pin levels through the synchronizer
    pinIn = 32'hA5A5_3C3C;
    repeat (3) step();
    busRead(4'd0, 32'hA5A5_3C3C, "R8");
    step();
    pinIn   = 32'h1234_5678;
    busAddr = 4'd0;
    expectVal(K_RD, 64'hA5A5_3C3C, "R8");
    busRead(4'd0, 32'h1234_5678, "R8");

    // R9: writes to the pin-level and unmapped addresses are ignored
    busWrite(4'd0, 32'hFFFF_FFFF);
    busWrite(4'd12, 32'hFFFF_FFFF);
    step();
    expectVal(K_OUT,  64'h0001_01EE, "R9");
    expectVal(K_OE,   64'hF0FF_0000, "R9");
    expectVal(K_PEN,  64'hFFFF_0000, "R9");
    expectVal(K_FUNC, 64'h39, "R9");
    busRead(4'd0, 32'h1234_5678, "R9");
    busRead(4'd12, 32'h0, "R9");
    busRead(4'd8, 32'h0001_0001, "R9");

    finishRun();
  end

endmodule